// File: doc/BRIEF.md
# Page Write Staging Buffer with Busy Polling

This block sits behind a serial-bus slave front end of a small byte-addressed non-volatile store. When a write transaction opens, the front end hands over the word address. Each data byte that follows goes into an eight-slot page buffer. The slot is picked by the low three address bits, and those bits step forward after every byte while the page bits stay put. A byte sent past the eighth slot wraps and replaces an earlier one. Nothing reaches the array while bytes are still arriving.

When the front end reports the stop condition, the block issues a single wide page write. This write carries the page number, all eight data slots and a mask of the slots that were actually filled. The block then holds `busy` high for a fixed number of clocks, which models the internal programming time. While `busy` is high, every input from the front end is ignored and no acknowledge is returned. A host therefore learns that the write has finished by repeating its address until an acknowledge appears. A stop that follows only an address, as in the setup phase of a random read, starts no programming cycle.

The updated address counter is always visible so that the read path can continue from it. When one cycle carries more than one event, the order of precedence is start, then byte, then stop. A lower-ranked event in that cycle is dropped.

Top module: `pgwr_buffer`

## Requirements
- R1: After an accepted start, each accepted byte is stored at slot offset = low 3 bits of the current address. The offset then increments modulo 8 and the upper address bits (the page) do not change.
- R2: When more than 8 bytes arrive before stop, the offset wraps and a later byte overwrites the earlier byte in the same slot. Only the last value of each slot is written.
- R3: `start_ack` is high for exactly the one cycle after an accepted `wr_begin`. `byte_ack` is high for exactly the one cycle after each accepted `byte_vld`.
- R4: No array write happens before stop. On an accepted `stop_pulse` with at least one buffered byte, `mem_we` is high for exactly one cycle, the cycle after the stop. During that cycle, `mem_wdata` bits 8k+7:8k hold slot k, `mem_wmask` bit k marks slot k as filled, and `mem_page` holds the page.
- R5: `busy` rises in the cycle after a committing stop and stays high for exactly `WR_CYCLES` cycles.
- R6: While `busy` is high, `wr_begin`, `byte_vld` and `stop_pulse` are ignored. No acknowledge is produced, and the buffer, the address counter and the array are not changed.
- R7: Once `busy` has fallen, a new `wr_begin` is acknowledged normally.
- R8: Only slots whose mask bit is set are written. Array locations that were not sent keep their old contents. A new start clears the mask, so bytes of an abandoned transaction are never written.
- R9: `addr_cnt` equals `wr_addr` after an accepted start. After a commit it equals the page followed by (last offset written + 1) mod 8.
- R10: A stop with no buffered byte produces no `mem_we` and leaves `busy` low.
- R11: After reset, `busy`, `mem_we`, `start_ack` and `byte_ack` are low and `addr_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_begin | input | 1 | One-cycle pulse: a write transaction opened, word address valid |
| wr_addr | input | ADDR_W | Word address that comes with `wr_begin` |
| byte_vld | input | 1 | One-cycle strobe: a data byte was received |
| byte_data | input | DATA_W | Data byte that comes with `byte_vld` |
| stop_pulse | input | 1 | One-cycle pulse: stop condition seen |
| start_ack | output | 1 | Acknowledge for an accepted start |
| byte_ack | output | 1 | Acknowledge for an accepted byte |
| mem_we | output | 1 | One-cycle page write strobe to the array |
| mem_page | output | ADDR_W-3 | Page number of the write |
| mem_wdata | output | 8*DATA_W | All eight slots, slot k at bits 8k+7:8k |
| mem_wmask | output | 8 | Per-slot write enable |
| busy | output | 1 | Internal programming cycle in progress |
| addr_cnt | output | ADDR_W | Current address counter value |

## Verification
A table of transactions covers several patterns, and each one distinguishes a different fault:
- A single byte separates correct masking from a full-page write.
- A run that starts mid-page and crosses the page end shows whether the offset wraps or carries into the page bits.
- A full aligned page, an unaligned full page and a ten-byte overrun separate overwrite-on-wrap from dropping or appending bytes.

After each transaction, the whole bench memory image is compared with a model filled with a known pattern, so that stray writes are caught. Directed cases cover these situations:
- an address-only stop;
- a restart that abandons buffered bytes;
- pokes on every input during the busy window;
- re-acknowledgement once busy has fallen.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RECV = 2'd1,
    CTL_PROG = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/pgwr_addr_ctr.sv
module pgwr_addr_ctr #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              inc,
  output logic [ADDR_W-OFF_W-1:0] base,
  output logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic [BASE_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  off_q, off_d;

  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    if (load) begin
      base_d = load_addr[ADDR_W-1:OFF_W];
      off_d  = load_addr[OFF_W-1:0];
    end else if (inc) begin
      off_d  = off_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load || inc) begin
      base_q <= base_d;
      off_q  <= off_d;
    end
  end

  assign base = base_q;
  assign off  = off_q;
  assign addr = {base_q, off_q};

  // R1
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> $stable(base_q));
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int OFF_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [SLOTS*DATA_W-1:0] data_flat,
  output logic [SLOTS-1:0]        mask
);
  logic [SLOTS-1:0] mask_q, mask_d;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] slot_q;

    assign hit = wr_en && (wr_off == OFF_W'(k));

    always_comb begin
      if (clear)     mask_d[k] = 1'b0;
      else if (hit)  mask_d[k] = 1'b1;
      else           mask_d[k] = mask_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q <= '0;
      else if (hit) slot_q <= wr_data;
    end

    assign data_flat[k*DATA_W +: DATA_W] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               mask_q <= '0;
    else if (clear || wr_en)  mask_q <= mask_d;
  end

  assign mask = mask_q;

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !wr_en) |=> (mask_q == '0));
endmodule

// File: rtl/pgwr_wcyc_timer.sv
module pgwr_wcyc_timer #(
  parameter int WR_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic last
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             last_w;

  assign last_w = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (launch) begin
      cnt_d  = LOAD_VAL;
      busy_d = 1'b1;
    end else if (last_w) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (launch || busy_q) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign last = last_w;

  // R5
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_q);
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 20
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_begin,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic                                   byte_vld,
  input  logic [DATA_W-1:0]                      byte_data,
  input  logic                                   stop_pulse,
  output logic                                   start_ack,
  output logic                                   byte_ack,
  output logic                                   mem_we,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   mem_page,
  output logic [PAGE_BYTES*DATA_W-1:0]           mem_wdata,
  output logic [PAGE_BYTES-1:0]                  mem_wmask,
  output logic                                   busy,
  output logic [ADDR_W-1:0]                      addr_cnt
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  ctl_state_e state_q, state_d;

  logic              tmr_busy, tmr_last;
  logic              acc_begin, acc_byte, acc_stop, commit;
  logic              start_ack_q, byte_ack_q, mem_we_q;
  logic [BASE_W-1:0] cur_base;
  logic [OFF_W-1:0]  cur_off;
  logic [PAGE_BYTES-1:0] buf_mask;

  // Event qualification: start outranks byte, byte outranks stop.
  assign acc_begin = wr_begin && !tmr_busy;
  assign acc_byte  = byte_vld && !wr_begin && (state_q == CTL_RECV);
  assign acc_stop  = stop_pulse && !wr_begin && !byte_vld && (state_q == CTL_RECV);
  assign commit    = acc_stop && (buf_mask != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CTL_IDLE: if (acc_begin) state_d = CTL_RECV;
      CTL_RECV: begin
        if (acc_begin)     state_d = CTL_RECV;
        else if (commit)   state_d = CTL_PROG;
        else if (acc_stop) state_d = CTL_IDLE;
      end
      CTL_PROG: if (tmr_last) state_d = CTL_IDLE;
      default:  state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CTL_IDLE;
      start_ack_q <= 1'b0;
      byte_ack_q  <= 1'b0;
      mem_we_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_ack_q <= acc_begin;
      byte_ack_q  <= acc_byte;
      mem_we_q    <= commit;
    end
  end

  pgwr_addr_ctr #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_actr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_begin),
    .load_addr (wr_addr),
    .inc       (acc_byte),
    .base      (cur_base),
    .off       (cur_off),
    .addr      (addr_cnt)
  );

  pgwr_page_buf #(
    .DATA_W (DATA_W),
    .SLOTS  (PAGE_BYTES),
    .OFF_W  (OFF_W)
  ) u_pbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (acc_begin),
    .wr_en     (acc_byte),
    .wr_off    (cur_off),
    .wr_data   (byte_data),
    .data_flat (mem_wdata),
    .mask      (buf_mask)
  );

  pgwr_wcyc_timer #(
    .WR_CYCLES (WR_CYCLES)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (commit),
    .busy   (tmr_busy),
    .last   (tmr_last)
  );

  assign start_ack = start_ack_q;
  assign byte_ack  = byte_ack_q;
  assign mem_we    = mem_we_q;
  assign mem_page  = cur_base;
  assign mem_wmask = buf_mask;
  assign busy      = tmr_busy;

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_q |=> !mem_we_q);

  // R4
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_q |-> tmr_busy);

  // R4
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_busy) |-> $past(stop_pulse));

  // R10
  we_has_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_q |-> (buf_mask != '0));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_busy && $past(tmr_busy)) |-> $stable(addr_cnt));

  // R3
  byte_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack_q |-> $past(byte_vld));
endmodule

// File: tb/sim_pgwr_buffer.sv
module sim_pgwr_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC     = 20;
  localparam int NVEC       = 6;
  // {start address, byte count, data seed, expected address counter}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h10, 8'd1,  8'h11, 8'h11},
    {8'h13, 8'd4,  8'h20, 8'h17},
    {8'h28, 8'd8,  8'h40, 8'h28},
    {8'h3E, 8'd3,  8'h60, 8'h39},
    {8'h48, 8'd10, 8'h80, 8'h4A},
    {8'h57, 8'd8,  8'hC3, 8'h57}
  };

  logic        clk, rst_n;
  logic        wr_begin, byte_vld, stop_pulse;
  logic [7:0]  wr_addr, byte_data;
  logic        start_ack, byte_ack, mem_we, busy;
  logic [4:0]  mem_page;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wmask, addr_cnt;

  int n_chk = 0;
  int n_err = 0;
  int we_count = 0;
  logic [7:0] mem_m [256];
  logic [7:0] exp_m [256];

  pgwr_buffer #(.WR_CYCLES(WR_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_pulse(stop_pulse),
    .start_ack(start_ack), .byte_ack(byte_ack), .mem_we(mem_we),
    .mem_page(mem_page), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .busy(busy), .addr_cnt(addr_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 3) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem_m[k] <= pat(k);
    end else if (mem_we) begin
      we_count <= we_count + 1;
      for (int k = 0; k < 8; k++)
        if (mem_wmask[k]) mem_m[{mem_page, 3'(k)}] <= mem_wdata[k*8 +: 8];
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int diffs();
    int d = 0;
    for (int k = 0; k < 256; k++) if (mem_m[k] !== exp_m[k]) d++;
    return d;
  endfunction

  task automatic do_begin(input logic [7:0] a, output logic ack);
    @(negedge clk); wr_begin = 1'b1; wr_addr = a;
    @(negedge clk); wr_begin = 1'b0; ack = start_ack;
  endtask

  task automatic do_byte(input logic [7:0] d, output logic ack);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0; ack = byte_ack;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack;
    int   nb, w0;
    wr_begin = 0; byte_vld = 0; stop_pulse = 0; wr_addr = 0; byte_data = 0;
    rst_n = 1'b0;
    for (int k = 0; k < 256; k++) exp_m[k] = pat(k);
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 mem_we", mem_we, 0);
    chk("R11 start_ack", start_ack, 0);
    chk("R11 byte_ack", byte_ack, 0);
    chk("R11 addr_cnt", addr_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, n, s, ec;
      {a, n, s, ec} = VEC[v];
      w0 = we_count;
      do_begin(a, ack);
      chk("R3 start ack", ack, 1);
      chk("R9 addr after start", addr_cnt, a);
      for (int i = 0; i < int'(n); i++) begin
        logic [7:0] d = 8'(s + 8'(i * 7));
        do_byte(d, ack);
        chk("R3 byte ack", ack, 1);
        exp_m[{a[7:3], 3'(a[2:0] + 3'(i))}] = d;
      end
      chk("R4 no write before stop", we_count - w0, 0);
      do_stop();
      chk("R5 busy after stop", busy, 1);
      wait_idle(nb);
      chk("R5 busy length", nb, WR_CYC);
      chk("R4 one page write", we_count - w0, 1);
      chk("R1 R2 R8 memory image", diffs(), 0);
      chk("R9 addr after commit", addr_cnt, ec);
    end

    // R10 address-only write
    w0 = we_count;
    do_begin(8'h70, ack);
    do_stop();
    for (int i = 0; i < 4; i++) begin
      chk("R10 busy stays low", busy, 0);
      @(negedge clk);
    end
    chk("R10 no write", we_count - w0, 0);
    chk("R9 addr after dummy", addr_cnt, 8'h70);

    // R8 restart abandons buffered bytes
    w0 = we_count;
    do_begin(8'h90, ack);
    do_byte(8'hEE, ack);
    do_begin(8'hA4, ack);
    do_byte(8'h5A, ack); exp_m[8'hA4] = 8'h5A;
    do_byte(8'h5B, ack); exp_m[8'hA5] = 8'h5B;
    do_stop();
    wait_idle(nb);
    chk("R8 restart image", diffs(), 0);
    chk("R8 restart one write", we_count - w0, 1);

    // R6 inputs ignored while busy, R7 ack returns after
    w0 = we_count;
    do_begin(8'h80, ack);
    do_byte(8'h01, ack); exp_m[8'h80] = 8'h01;
    do_byte(8'h02, ack); exp_m[8'h81] = 8'h02;
    do_stop();
    do_begin(8'hC0, ack);
    chk("R6 no start ack when busy", ack, 0);
    do_byte(8'h77, ack);
    chk("R6 no byte ack when busy", ack, 0);
    do_stop();
    chk("R6 addr held", addr_cnt, 8'h82);
    wait_idle(nb);
    chk("R6 single write", we_count - w0, 1);
    chk("R6 image untouched by busy pokes", diffs(), 0);
    do_begin(8'hC0, ack);
    chk("R7 ack after busy", ack, 1);
    do_stop();
    chk("R7 dummy no busy", busy, 0);

    finish_run();
  end
endmodule